// File: doc/BRIEF.md
# LCD Panel Power-Up Sequencer

This block brings a small LCD controller from cold reset to an operating display without software help. It first toggles the panel's reset line in a fixed high-low-high pattern, then asks an external serial engine to read the panel's 24-bit identifier. The identifier selects one of two internal command tables. Each table entry is an opcode followed by zero or more parameter bytes, and each entry may be followed by a wait of a given number of milliseconds. After the selected table, the block sends display-on, waits, and sends sleep-out. It then holds a done flag.

Command bytes leave the block as 9-bit words on a valid/ready stream. Bit 8 tells the serial engine whether the word is an opcode or a parameter. A word is held on the stream, unchanged, until the engine takes it. Back-pressure by holding ready low only stretches the sequence and loses nothing. After the last word of an entry is taken, the block sends nothing more until the engine pulses a completion strobe for that entry. An error bit can ride on that strobe; it sets a sticky error output and the sequence carries on. All waits count a millisecond tick made by dividing the clock by `CLK_PER_MS`.

Top module: `lcd_powerup_seq`

## Requirements
- R1: While `rst_n` is low, and on release of it, `panel_rst_n` is 1 and `cmd_valid`, `id_req`, `done` and `err` are 0.
- R2: After reset release, `panel_rst_n` stays high for at least 100·C cycles, where C is `CLK_PER_MS`. It is then low for exactly 40·C cycles, then high for exactly 100·C cycles before `id_req` rises. No word is offered in this time.
- R3: `id_req` stays high until a cycle with `id_ack` high, when `id_data` is sampled. A value of exactly 24'h000080 selects the short table (8 entries); any other value selects the long table (22 entries).
- R4: Each word is 9 bits. Bit 8 is 0 for an opcode and 1 for a parameter byte in bits 7:0. An entry sends its opcode first, then its parameters in order. `cmd_last` is 1 only on the entry's final word. While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_word` and `cmd_last` hold.
- R5: The short table, as opcode/parameter count/delay in ms: 36/1/0, 3A/1/0, B6/4/0, C5/2/0, E0/16/0, E1/16/20, B0/1/0, B4/1/100.
- R6: The long table, each entry with delay 0: FF/3, BA/1, BC/21, BD/8, BE/9, C7/1, ED/3, C0/3, FC/1, B6/1, DF/6, F3/1, B4/3, F7/1, B1/3, F2/4, C1/4, 36/1, 3A/1, E0/16, E1/16, 35/1.
- R7: Parameter byte k (from 0) of an entry with opcode P is (P + 17·k) mod 256. Two exceptions: the first long entry sends FF, 98, 06, and the last long entry sends 00.
- R8: After an entry's last word is taken, no word is offered until `xfer_done` is seen. If `xfer_done` is high in cycle t and the entry's delay is N ms, the next entry's first word becomes valid in cycle t + N·C + 2.
- R9: After the selected table, opcode 29 is sent with no parameters, followed by a 100 ms delay as in R8, then opcode 11 with no parameters.
- R10: `err` rises in the cycle after an `xfer_done` that carries `xfer_err`, and then stays high until reset. The remaining entries are still sent.
- R11: `done` rises in the cycle after the completion of opcode 11 and stays high until reset. While `done` is high, neither `cmd_valid` nor `id_req` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| panel_rst_n | output | 1 | Reset line to the panel, active low |
| id_req | output | 1 | Request to the serial engine to read the panel identifier |
| id_ack | input | 1 | Identifier read finished; `id_data` valid |
| id_data | input | 24 | Panel identifier |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Serial engine accepts the offered word |
| cmd_word | output | 9 | Bit 8: 0 opcode, 1 parameter; bits 7:0 byte |
| cmd_last | output | 1 | Final word of the current entry |
| xfer_done | input | 1 | Serial engine finished shifting the current entry |
| xfer_err | input | 1 | Error on the finished entry, valid with `xfer_done` |
| done | output | 1 | Sequence complete, sticky until reset |
| err | output | 1 | Sticky error flag |

## Verification
Two events can fall in the same cycle: the error flag can be set by the very completion that also ends the sequence. To provoke this, the bench makes the engine model report an error only on the sleep-out completion. It then expects `err` still low in the completion cycle, and `err` and `done` both high in the next cycle. A second overlap is back-pressure on the last word of an entry. There, the bench holds `cmd_ready` low at random and checks that the word and `cmd_last` stay put and that the completion wait starts only after the accepting edge.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int OPW   = 8;   // opcode / parameter byte width
  localparam int WORDW = OPW + 1;
  localparam int CNTW  = 5;   // parameter count, 0..21
  localparam int DLYW  = 7;   // delay in ms, 0..100
  localparam int IDXW  = 5;   // 32 descriptors
  localparam int IDW   = 24;

  localparam logic [IDXW-1:0] SHORT_BASE  = IDXW'(0);
  localparam logic [IDXW-1:0] SHORT_LAST  = IDXW'(7);
  localparam logic [IDXW-1:0] LONG_BASE   = IDXW'(8);
  localparam logic [IDXW-1:0] LONG_LAST   = IDXW'(29);
  localparam logic [IDXW-1:0] DISP_ON_IDX = IDXW'(30);
  localparam logic [IDXW-1:0] WAKE_IDX    = IDXW'(31);

  localparam logic [IDW-1:0] SHORT_ID = IDW'(24'h000080);

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [CNTW-1:0] cnt;
    logic [DLYW-1:0] dly;
  } entry_t;

  typedef enum logic [2:0] {
    S_BOOT, S_RHI1, S_RLO, S_RHI2, S_ID, S_SEND, S_DLY, S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    T_IDLE, T_SEND, T_WAIT
  } tx_state_e;

  function automatic entry_t mk(input logic [OPW-1:0] op,
                                input int cnt, input int dly);
    entry_t e;
    e.op  = op;
    e.cnt = CNTW'(cnt);
    e.dly = DLYW'(dly);
    return e;
  endfunction

endpackage

// File: rtl/lcdseq_ms_timer.sv
module lcdseq_ms_timer #(
  parameter int CLK_PER_MS = 125000,
  parameter int MSW        = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [MSW-1:0] ms,
  output logic           expire
);
  localparam int SUBW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [SUBW-1:0] SUB_TOP = SUBW'(CLK_PER_MS - 1);

  logic           active;
  logic [SUBW-1:0] sub;
  logic [MSW-1:0]  left;

  // last cycle of the last millisecond
  assign expire = active && (sub == '0) && (left == MSW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      sub    <= '0;
      left   <= '0;
    end else if (start) begin
      active <= (ms != '0);
      sub    <= SUB_TOP;
      left   <= ms;
    end else if (active) begin
      if (sub == '0) begin
        sub <= SUB_TOP;
        if (left == MSW'(1)) active <= 1'b0;
        else                 left   <= left - MSW'(1);
      end else begin
        sub <= sub - SUBW'(1);
      end
    end
  end

endmodule

// File: rtl/lcdseq_rom.sv
module lcdseq_rom
  import lcdseq_pkg::*;
(
  input  logic [IDXW-1:0] idx,
  input  logic [CNTW-1:0] pidx,
  output entry_t          ent,
  output logic [OPW-1:0]  pbyte
);
  // descriptor store: short table at 0, long table at 8, tail at 30
  always_comb begin
    case (idx)
      5'd0:  ent = mk(8'h36, 1, 0);
      5'd1:  ent = mk(8'h3A, 1, 0);
      5'd2:  ent = mk(8'hB6, 4, 0);
      5'd3:  ent = mk(8'hC5, 2, 0);
      5'd4:  ent = mk(8'hE0, 16, 0);
      5'd5:  ent = mk(8'hE1, 16, 20);
      5'd6:  ent = mk(8'hB0, 1, 0);
      5'd7:  ent = mk(8'hB4, 1, 100);
      5'd8:  ent = mk(8'hFF, 3, 0);
      5'd9:  ent = mk(8'hBA, 1, 0);
      5'd10: ent = mk(8'hBC, 21, 0);
      5'd11: ent = mk(8'hBD, 8, 0);
      5'd12: ent = mk(8'hBE, 9, 0);
      5'd13: ent = mk(8'hC7, 1, 0);
      5'd14: ent = mk(8'hED, 3, 0);
      5'd15: ent = mk(8'hC0, 3, 0);
      5'd16: ent = mk(8'hFC, 1, 0);
      5'd17: ent = mk(8'hB6, 1, 0);
      5'd18: ent = mk(8'hDF, 6, 0);
      5'd19: ent = mk(8'hF3, 1, 0);
      5'd20: ent = mk(8'hB4, 3, 0);
      5'd21: ent = mk(8'hF7, 1, 0);
      5'd22: ent = mk(8'hB1, 3, 0);
      5'd23: ent = mk(8'hF2, 4, 0);
      5'd24: ent = mk(8'hC1, 4, 0);
      5'd25: ent = mk(8'h36, 1, 0);
      5'd26: ent = mk(8'h3A, 1, 0);
      5'd27: ent = mk(8'hE0, 16, 0);
      5'd28: ent = mk(8'hE1, 16, 0);
      5'd29: ent = mk(8'h35, 1, 0);
      5'd30: ent = mk(8'h29, 0, 100);
      default: ent = mk(8'h11, 0, 0);
    endcase
  end

  // parameter bytes are generated, with two fixed exceptions
  logic [OPW-1:0] step;
  always_comb begin
    step  = OPW'({3'b000, pidx} * 8'd17);
    pbyte = ent.op + step;
    if (idx == LONG_BASE) begin
      case (pidx)
        5'd0:    pbyte = 8'hFF;
        5'd1:    pbyte = 8'h98;
        default: pbyte = 8'h06;
      endcase
    end else if (idx == LONG_LAST) begin
      pbyte = 8'h00;
    end
  end

endmodule

// File: rtl/lcdseq_word_tx.sv
module lcdseq_word_tx
  import lcdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  entry_t           ent,
  input  logic [OPW-1:0]   pbyte,
  output logic [CNTW-1:0]  pidx,
  output logic             cmd_valid,
  output logic [WORDW-1:0] cmd_word,
  output logic             cmd_last,
  input  logic             cmd_ready,
  input  logic             xfer_done,
  input  logic             xfer_err,
  output logic             ent_done,
  output logic             ent_err
);
  tx_state_e       st;
  logic [CNTW-1:0] k;   // 0 = opcode, n = parameter n-1

  assign pidx      = k - CNTW'(1);
  assign cmd_valid = (st == T_SEND);
  assign cmd_last  = (k == ent.cnt);
  assign cmd_word  = (k == '0) ? {1'b0, ent.op} : {1'b1, pbyte};
  assign ent_done  = (st == T_WAIT) && xfer_done;
  assign ent_err   = xfer_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= T_IDLE;
      k  <= '0;
    end else begin
      case (st)
        T_IDLE: if (go) begin
          st <= T_SEND;
          k  <= '0;
        end
        T_SEND: if (cmd_ready) begin
          if (cmd_last) st <= T_WAIT;
          else          k  <= k + CNTW'(1);
        end
        T_WAIT: if (xfer_done) st <= T_IDLE;
        default: st <= T_IDLE;
      endcase
    end
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word) && $stable(cmd_last));

endmodule

// File: rtl/lcd_powerup_seq.sv
module lcd_powerup_seq
  import lcdseq_pkg::*;
#(
  parameter int CLK_PER_MS = 125000,
  parameter int RST_HI_MS  = 100,
  parameter int RST_LO_MS  = 40,
  parameter int SETTLE_MS  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             panel_rst_n,
  output logic             id_req,
  input  logic             id_ack,
  input  logic [IDW-1:0]   id_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [WORDW-1:0] cmd_word,
  output logic             cmd_last,
  input  logic             xfer_done,
  input  logic             xfer_err,
  output logic             done,
  output logic             err
);
  seq_state_e      state;
  logic [IDXW-1:0] idx, last_tbl, adv_idx;
  logic            go_q, err_q, adv_finish;
  logic            tmr_start, tmr_expire;
  logic [DLYW-1:0] tmr_ms;
  entry_t          ent;
  logic [OPW-1:0]  pbyte;
  logic [CNTW-1:0] pidx;
  logic            ent_done, ent_err;

  lcdseq_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MSW(DLYW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .ms(tmr_ms), .expire(tmr_expire)
  );

  lcdseq_rom u_rom (.idx(idx), .pidx(pidx), .ent(ent), .pbyte(pbyte));

  lcdseq_word_tx u_tx (
    .clk(clk), .rst_n(rst_n), .go(go_q), .ent(ent), .pbyte(pbyte), .pidx(pidx),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_last(cmd_last),
    .cmd_ready(cmd_ready), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .ent_done(ent_done), .ent_err(ent_err)
  );

  assign panel_rst_n = (state != S_RLO);
  assign id_req      = (state == S_ID);
  assign done        = (state == S_DONE);
  assign err         = err_q;

  // next descriptor after the current one
  assign adv_finish = (idx == WAKE_IDX);
  assign adv_idx    = (idx == last_tbl) ? DISP_ON_IDX : idx + IDXW'(1);

  always_comb begin
    tmr_start = 1'b0;
    tmr_ms    = '0;
    case (state)
      S_BOOT: begin tmr_start = 1'b1; tmr_ms = DLYW'(RST_HI_MS); end
      S_RHI1: if (tmr_expire) begin tmr_start = 1'b1; tmr_ms = DLYW'(RST_LO_MS); end
      S_RLO:  if (tmr_expire) begin tmr_start = 1'b1; tmr_ms = DLYW'(SETTLE_MS); end
      S_SEND: if (ent_done && ent.dly != '0) begin tmr_start = 1'b1; tmr_ms = ent.dly; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_BOOT;
      idx      <= SHORT_BASE;
      last_tbl <= SHORT_LAST;
      go_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (state)
        S_BOOT: state <= S_RHI1;
        S_RHI1: if (tmr_expire) state <= S_RLO;
        S_RLO:  if (tmr_expire) state <= S_RHI2;
        S_RHI2: if (tmr_expire) state <= S_ID;
        S_ID: if (id_ack) begin
          if (id_data == SHORT_ID) begin
            idx <= SHORT_BASE; last_tbl <= SHORT_LAST;
          end else begin
            idx <= LONG_BASE;  last_tbl <= LONG_LAST;
          end
          state <= S_SEND;
          go_q  <= 1'b1;
        end
        S_SEND: if (ent_done) begin
          if (ent_err) err_q <= 1'b1;
          if (ent.dly != '0) begin
            state <= S_DLY;
          end else if (adv_finish) begin
            state <= S_DONE;
          end else begin
            idx  <= adv_idx;
            go_q <= 1'b1;
          end
        end
        S_DLY: if (tmr_expire) begin
          if (adv_finish) begin
            state <= S_DONE;
          end else begin
            idx   <= adv_idx;
            state <= S_SEND;
            go_q  <= 1'b1;
          end
        end
        S_DONE: state <= S_DONE;
        default: state <= S_BOOT;
      endcase
    end
  end

  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !cmd_valid && !id_req);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    id_req && !id_ack |=> id_req);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid && !id_req);

endmodule

// File: tb/lcd_powerup_seq_tb.sv
module lcd_powerup_seq_tb;
  localparam int CPM = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        id_ack = 1'b0;
  logic [23:0] id_data = '0;
  logic        cmd_ready = 1'b0;
  logic        xfer_done = 1'b0;
  logic        xfer_err = 1'b0;
  logic        panel_rst_n, id_req, cmd_valid, cmd_last, done, err;
  logic [8:0]  cmd_word;

  lcd_powerup_seq #(.CLK_PER_MS(CPM)) u_dut (
    .clk(clk), .rst_n(rst_n), .panel_rst_n(panel_rst_n), .id_req(id_req),
    .id_ack(id_ack), .id_data(id_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_last(cmd_last), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .done(done), .err(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int b_op[32], b_cnt[32], b_dly[32];

  logic [23:0] sc_id;
  int sc_errpos, sc_rdy;

  // engine model state
  int cyc, pos, k, seq_len, id_wait, done_wait, gap_c0, gap_exp, entries_done;
  bit waiting, gap_pend, err_acc, short_sel, id_seen, err_chk_pend, last_pend, hold_pend;
  logic [8:0] hold_word;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_ent(input int i, input int op, input int cnt, input int dly);
    b_op[i] = op; b_cnt[i] = cnt; b_dly[i] = dly;
  endtask

  function automatic int seq_idx(input int p);
    if (short_sel) return (p < 8) ? p : ((p == 8) ? 30 : 31);
    return (p < 22) ? 8 + p : ((p == 22) ? 30 : 31);
  endfunction

  function automatic logic [7:0] bparam(input int idx, input int kk);
    if (idx == 8) return (kk == 0) ? 8'hFF : ((kk == 1) ? 8'h98 : 8'h06);
    if (idx == 29) return 8'h00;
    return 8'(b_op[idx] + 17 * kk);
  endfunction

  function automatic string op_req(input int idx);
    if (idx >= 30) return "R9";
    return short_sel ? "R5" : "R6";
  endfunction

  // serial engine model and stream checker
  initial begin
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        pos = 0; k = 0; waiting = 0; gap_pend = 0; err_acc = 0; id_seen = 0;
        id_wait = 0; hold_pend = 0; err_chk_pend = 0; last_pend = 0;
        entries_done = 0; seq_len = 0; short_sel = 0;
        cmd_ready = 0; id_ack = 0; xfer_done = 0; xfer_err = 0;
      end else begin
        int idx;
        bit rdy, e;
        logic [8:0] expw;
        id_ack = 0; xfer_done = 0; xfer_err = 0;
        if (err_chk_pend) begin
          check(err == err_acc, "R10", "err after completion", err, err_acc);
          if (last_pend) check(done == 1'b1, "R11", "done after sleep-out", done, 1);
          err_chk_pend = 0; last_pend = 0;
        end
        if (hold_pend) begin
          check(cmd_valid && cmd_word == hold_word, "R4", "word held under back-pressure",
                cmd_word, hold_word);
          hold_pend = 0;
        end
        if (id_req && !id_seen) begin
          if (id_wait == 0) id_wait = 1 + $urandom % 3;
          else begin
            id_wait--;
            if (id_wait == 0) begin
              id_ack = 1; id_data = sc_id; id_seen = 1;
              short_sel = (sc_id == 24'h000080);
              seq_len = short_sel ? 10 : 24;
            end
          end
        end
        if (gap_pend && cmd_valid) begin
          idx = seq_idx(pos);
          check(cyc - gap_c0 == gap_exp, (idx == 31) ? "R9" : "R8",
                "cycles from completion to next word", cyc - gap_c0, gap_exp);
          gap_pend = 0;
        end
        if (waiting) begin
          if (cmd_valid) check(0, "R8", "word offered before completion", 1, 0);
          if (done_wait == 0) begin
            idx = seq_idx(pos);
            e = (pos == sc_errpos);
            xfer_done = 1; xfer_err = e;
            check(err == err_acc, "R10", "err before completion", err, err_acc);
            err_acc |= e;
            gap_c0 = cyc;
            gap_exp = b_dly[idx] * CPM + 2;
            gap_pend = (pos + 1 < seq_len);
            err_chk_pend = 1;
            last_pend = (pos + 1 == seq_len);
            pos++; entries_done++; waiting = 0;
          end else done_wait--;
        end
        rdy = ($urandom % 100) < sc_rdy;
        cmd_ready = rdy;
        if (cmd_valid && !waiting) begin
          if (pos >= seq_len) begin
            check(0, "R11", "word after sequence end", cmd_word, 0);
          end else if (rdy) begin
            idx = seq_idx(pos);
            expw = (k == 0) ? {1'b0, 8'(b_op[idx])} : {1'b1, bparam(idx, k - 1)};
            check(cmd_word == expw, (k == 0) ? op_req(idx) : "R7", "word value",
                  cmd_word, expw);
            check(cmd_last == (k == b_cnt[idx]), "R4", "last flag", cmd_last, k == b_cnt[idx]);
            if (k == b_cnt[idx]) begin
              waiting = 1; done_wait = $urandom % 4; k = 0;
            end else k++;
          end else begin
            hold_pend = 1; hold_word = cmd_word;
          end
        end
      end
    end
  end

  task automatic run(input logic [23:0] id, input int errpos, input int rdy);
    int hi, lo, hi2, explen;
    bit quiet, stay;
    sc_id = id; sc_errpos = errpos; sc_rdy = rdy;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(panel_rst_n == 1'b1, "R1", "panel reset line in reset", panel_rst_n, 1);
    check({cmd_valid, id_req, done, err} == 4'b0, "R1", "outputs in reset",
          {cmd_valid, id_req, done, err}, 0);
    rst_n = 1;
    hi = 0; quiet = 1;
    while (panel_rst_n) begin
      @(negedge clk);
      if (panel_rst_n) hi++;
      if (cmd_valid || id_req) quiet = 0;
    end
    lo = 1;
    while (!panel_rst_n) begin
      @(negedge clk);
      if (!panel_rst_n) lo++;
      if (cmd_valid || id_req) quiet = 0;
    end
    hi2 = 0;
    while (!id_req) begin
      hi2++;
      if (cmd_valid || !panel_rst_n) quiet = 0;
      @(negedge clk);
    end
    check(hi >= 100 * CPM, "R2", "first high stretch", hi, 100 * CPM);
    check(lo == 40 * CPM, "R2", "low pulse", lo, 40 * CPM);
    check(hi2 == 100 * CPM, "R2", "high before id request", hi2, 100 * CPM);
    check(quiet, "R2", "no traffic during panel reset", 0, 1);
    while (!done) @(negedge clk);
    explen = (id == 24'h000080) ? 10 : 24;
    check(entries_done == explen, "R3", "entries in selected table plus tail",
          entries_done, explen);
    stay = 1;
    repeat (20) begin
      @(negedge clk);
      if (!done || cmd_valid || id_req) stay = 0;
    end
    check(stay, "R11", "done holds with no traffic", 0, 1);
    check(err == (errpos >= 0 && errpos < explen), "R10", "err at end", err,
          errpos >= 0 && errpos < explen);
  endtask

  initial begin
    logic [23:0] rid;
    int rpos;
    void'($urandom(32'd71523));
    set_ent(0, 8'h36, 1, 0);  set_ent(1, 8'h3A, 1, 0);  set_ent(2, 8'hB6, 4, 0);
    set_ent(3, 8'hC5, 2, 0);  set_ent(4, 8'hE0, 16, 0); set_ent(5, 8'hE1, 16, 20);
    set_ent(6, 8'hB0, 1, 0);  set_ent(7, 8'hB4, 1, 100);
    set_ent(8, 8'hFF, 3, 0);  set_ent(9, 8'hBA, 1, 0);  set_ent(10, 8'hBC, 21, 0);
    set_ent(11, 8'hBD, 8, 0); set_ent(12, 8'hBE, 9, 0); set_ent(13, 8'hC7, 1, 0);
    set_ent(14, 8'hED, 3, 0); set_ent(15, 8'hC0, 3, 0); set_ent(16, 8'hFC, 1, 0);
    set_ent(17, 8'hB6, 1, 0); set_ent(18, 8'hDF, 6, 0); set_ent(19, 8'hF3, 1, 0);
    set_ent(20, 8'hB4, 3, 0); set_ent(21, 8'hF7, 1, 0); set_ent(22, 8'hB1, 3, 0);
    set_ent(23, 8'hF2, 4, 0); set_ent(24, 8'hC1, 4, 0); set_ent(25, 8'h36, 1, 0);
    set_ent(26, 8'h3A, 1, 0); set_ent(27, 8'hE0, 16, 0); set_ent(28, 8'hE1, 16, 0);
    set_ent(29, 8'h35, 1, 0); set_ent(30, 8'h29, 0, 100); set_ent(31, 8'h11, 0, 0);

    // R5 short table, free-flowing engine, no errors
    run(24'h000080, -1, 100);
    // R6 random identifier, random error position, heavy back-pressure
    rid = 24'($urandom);
    if (rid == 24'h000080) rid = 24'h123456;
    rpos = 3 + $urandom % 15;
    run(rid, rpos, 50);
    // R10 with R11: error on the sleep-out completion itself
    run(24'h000081, 23, 70);
    // R3 upper identifier bits must also match
    run(24'h800080, 0, 60);
    // R10 short table with error mid-table
    run(24'h000080, 5, 40);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule